// File: doc/BRIEF.md
# Trace Cache Lookup and Hit Logic

This block is a direct-mapped store of instruction traces: runs of up to sixteen instructions kept in the order they were executed, with up to three conditional branches inside. It sits next to the instruction cache in a fetch front end. In each cycle the fetch stage presents a fetch address and the branch predictor's directions for the next three conditional branches. One cycle later the block reports whether a stored trace matches. On a hit it also returns the trace's instruction words, how many of them are valid, and the address at which fetch continues after the trace.

A line matches when all of the following are true: the line is valid, its tag equals the fetch address, and the branch directions recorded in the line agree with the current prediction. The directions are compared only for the branches the trace actually holds. The direction of a trace's closing branch is not part of the match. That direction instead chooses the continuation address: the stored target address if the branch is predicted taken, otherwise the stored fall-through address. A separate write port takes a finished trace and its control fields from a fill unit and places it in the line selected by the trace's starting address.

Top module: `trace_lookup_top`

## Requirements
- R1: After reset every line is invalid, so every lookup misses until a trace has been written at its index.
- R2: A lookup presented with `req_valid` high is answered on the outputs after the next rising clock edge, and the outputs hold until the edge that follows.
- R3: The line index is `req_addr[OFFSET_W +: log2(LINES)]`. The tag is every other address bit, including the offset bits. A lookup whose tag differs from the stored one misses, even when the index is the same.
- R4: The number of compared directions is `br_count - 1` when the trace ends in a branch and `br_count` when it does not. Prediction bit i (bit 0 is the first branch) is compared with stored flag i for each i below that number. Any difference gives a miss.
- R5: Prediction bits at or above the compared number do not affect the hit or the instruction outputs.
- R6: On a hit for a trace that ends in a branch, `next_addr` is the stored target address if prediction bit `br_count - 1` is 1, and the stored fall-through address if it is 0.
- R7: On a hit for a trace that does not end in a branch, `next_addr` is the stored fall-through address, whatever the prediction.
- R8: On a hit, `insns` and `insn_count` carry the stored words and count. On a miss, `hit`, `insn_count`, `insns` and `next_addr` are all zero.
- R9: A lookup in the same cycle as a write to the same index sees the line's old contents. The next lookup sees the new contents.
- R10: A cycle with `req_valid` low produces no hit on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | 32 | Fetch address |
| req_pred | input | 3 | Predicted directions, bit 0 = first branch, 1 = taken |
| wr_en | input | 1 | Write a finished trace |
| wr_start_addr | input | 32 | Starting address of the written trace |
| wr_insns | input | 16*INSN_W | Instruction words, word 0 in the low bits |
| wr_count | input | 5 | Number of valid instructions |
| wr_br_count | input | 2 | Number of conditional branches in the trace |
| wr_ends_br | input | 1 | Trace closes with a branch |
| wr_dir_flags | input | 3 | Recorded directions, bit 0 = first branch |
| wr_fall_addr | input | 32 | Fall-through continuation address |
| wr_target_addr | input | 32 | Taken-path continuation address |
| hit | output | 1 | Lookup matched |
| insns | output | 16*INSN_W | Instruction words of the matched trace |
| insn_count | output | 5 | Valid instruction count |
| next_addr | output | 32 | Address where fetch continues |

## Verification
Two cases are hard to reach from the ports. The first is a lookup that collides with a write to the same line in the same cycle. The bench drives both ports on the same clock edge and checks for the old continuation address, then checks for the new one on the next lookup. The second is a prediction that differs from the stored flags only in the bits the mask excludes. Traces are preloaded with different branch counts and closing kinds. The vector table then flips the excluded prediction bits and the compared bits separately. With this setup, a mask that is off by one in either direction turns an expected hit into a miss, or an expected miss into a hit.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int TC_ADDR_W    = 32;
    localparam int TC_MAX_BR    = 3;
    localparam int TC_BRC_W     = $clog2(TC_MAX_BR + 1);
    localparam int TC_MAX_INSNS = 16;
    localparam int TC_CNT_W     = $clog2(TC_MAX_INSNS + 1);

    typedef struct packed {
        logic [TC_BRC_W-1:0]  br_count;
        logic                 ends_br;
        logic [TC_MAX_BR-1:0] dir_flags;
        logic [TC_CNT_W-1:0]  insn_count;
        logic [TC_ADDR_W-1:0] fall_addr;
        logic [TC_ADDR_W-1:0] target_addr;
    } tc_ctrl_t;
endpackage

// File: rtl/tc_ctrl_store.sv
module tc_ctrl_store
    import trace_pkg::*;
#(
    parameter int LINES = 64,
    parameter int TAG_W = 26,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  tc_ctrl_t         wr_ctrl,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output tc_ctrl_t         rd_ctrl
);
    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_mem  [LINES];
    tc_ctrl_t         ctrl_mem [LINES];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            ctrl_mem[wr_idx] <= wr_ctrl;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_ctrl  = ctrl_mem[rd_idx];

    // R1: the first cycle out of reset starts with an empty store
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));
endmodule

// File: rtl/tc_data_store.sv
module tc_data_store #(
    parameter int LINES  = 64,
    parameter int LINE_W = 512,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line
);
    logic [LINE_W-1:0] line_mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) line_mem[wr_idx] <= wr_line;
    end

    assign rd_line = line_mem[rd_idx];
endmodule

// File: rtl/tc_hit_eval.sv
module tc_hit_eval
    import trace_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic                 req_valid,
    input  logic [TAG_W-1:0]     req_tag,
    input  logic [TC_MAX_BR-1:0] req_pred,
    input  logic                 line_valid,
    input  logic [TAG_W-1:0]     line_tag,
    input  tc_ctrl_t             line_ctrl,
    output logic                 hit,
    output logic [TC_ADDR_W-1:0] cont_addr
);
    logic [TC_BRC_W-1:0]  cmp_n;
    logic [TC_MAX_BR-1:0] cmp_mask;
    logic                 last_taken;

    always_comb begin
        if (line_ctrl.ends_br && line_ctrl.br_count != '0)
            cmp_n = line_ctrl.br_count - TC_BRC_W'(1);
        else if (line_ctrl.ends_br)
            cmp_n = '0;
        else
            cmp_n = line_ctrl.br_count;
    end

    for (genvar i = 0; i < TC_MAX_BR; i++) begin : g_mask
        assign cmp_mask[i] = (TC_BRC_W'(i) < cmp_n);
    end

    always_comb begin
        last_taken = 1'b0;
        for (int i = 0; i < TC_MAX_BR; i++) begin
            if (line_ctrl.ends_br && line_ctrl.br_count == TC_BRC_W'(i + 1))
                last_taken = req_pred[i];
        end
    end

    assign hit = req_valid && line_valid && (line_tag == req_tag)
                 && (((line_ctrl.dir_flags ^ req_pred) & cmp_mask) == '0);
    assign cont_addr = last_taken ? line_ctrl.target_addr : line_ctrl.fall_addr;
endmodule

// File: rtl/trace_lookup_top.sv
module trace_lookup_top
    import trace_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int LINES    = 64,
    parameter int OFFSET_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [TC_ADDR_W-1:0]           req_addr,
    input  logic [TC_MAX_BR-1:0]           req_pred,
    input  logic                           wr_en,
    input  logic [TC_ADDR_W-1:0]           wr_start_addr,
    input  logic [TC_MAX_INSNS*INSN_W-1:0] wr_insns,
    input  logic [TC_CNT_W-1:0]            wr_count,
    input  logic [TC_BRC_W-1:0]            wr_br_count,
    input  logic                           wr_ends_br,
    input  logic [TC_MAX_BR-1:0]           wr_dir_flags,
    input  logic [TC_ADDR_W-1:0]           wr_fall_addr,
    input  logic [TC_ADDR_W-1:0]           wr_target_addr,
    output logic                           hit,
    output logic [TC_MAX_INSNS*INSN_W-1:0] insns,
    output logic [TC_CNT_W-1:0]            insn_count,
    output logic [TC_ADDR_W-1:0]           next_addr
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = TC_ADDR_W - IDX_W;
    localparam int LINE_W = TC_MAX_INSNS * INSN_W;

    typedef struct packed {
        logic                 hit;
        logic [LINE_W-1:0]    insns;
        logic [TC_CNT_W-1:0]  count;
        logic [TC_ADDR_W-1:0] next;
    } out_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [TC_ADDR_W-1:0] a);
        return a[OFFSET_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [TC_ADDR_W-1:0] a);
        return {a[TC_ADDR_W-1:OFFSET_W+IDX_W], a[OFFSET_W-1:0]};
    endfunction

    tc_ctrl_t          wr_ctrl, rd_ctrl;
    logic              rd_valid, lookup_hit;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic [TC_ADDR_W-1:0] cont_addr;
    out_t out_d, out_q;

    always_comb begin
        wr_ctrl.br_count    = wr_br_count;
        wr_ctrl.ends_br     = wr_ends_br;
        wr_ctrl.dir_flags   = wr_dir_flags;
        wr_ctrl.insn_count  = wr_count;
        wr_ctrl.fall_addr   = wr_fall_addr;
        wr_ctrl.target_addr = wr_target_addr;
    end

    tc_ctrl_store #(.LINES(LINES), .TAG_W(TAG_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (idx_of(wr_start_addr)),
        .wr_tag   (tag_of(wr_start_addr)),
        .wr_ctrl  (wr_ctrl),
        .rd_idx   (idx_of(req_addr)),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_ctrl  (rd_ctrl)
    );

    tc_data_store #(.LINES(LINES), .LINE_W(LINE_W)) data_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (idx_of(wr_start_addr)),
        .wr_line (wr_insns),
        .rd_idx  (idx_of(req_addr)),
        .rd_line (rd_line)
    );

    tc_hit_eval #(.TAG_W(TAG_W)) eval_i (
        .req_valid  (req_valid),
        .req_tag    (tag_of(req_addr)),
        .req_pred   (req_pred),
        .line_valid (rd_valid),
        .line_tag   (rd_tag),
        .line_ctrl  (rd_ctrl),
        .hit        (lookup_hit),
        .cont_addr  (cont_addr)
    );

    always_comb begin
        out_d = '0;
        if (lookup_hit) begin
            out_d.hit   = 1'b1;
            out_d.insns = rd_line;
            out_d.count = rd_ctrl.insn_count;
            out_d.next  = cont_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hit        = out_q.hit;
    assign insns      = out_q.insns;
    assign insn_count = out_q.count;
    assign next_addr  = out_q.next;

    // R2, R10: a hit answers a request made one edge earlier
    a_r10_hit_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(req_valid));

    // R8: a miss presents all-zero results
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (insn_count == '0 && next_addr == '0 && insns == '0));

    // R8: a returned count never exceeds the trace width
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (insn_count <= TC_CNT_W'(TC_MAX_INSNS)));

    // R2: results are stable while no request is presented
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!req_valid) && !req_valid && $past(rst_n)) |=> !hit);
endmodule

// File: tb/trace_lookup_top_tb_top.sv
module trace_lookup_top_tb_top;
    localparam int AW = 32;
    localparam int IW = 32;
    localparam int NI = 16;
    localparam int LW = NI * IW;
    localparam int VW = AW + 3 + 1 + 5 + AW;
    localparam int NV = 13;

    // {fetch addr, pred, exp hit, exp count, exp next}
    localparam logic [VW-1:0] VEC [NV] = '{
        {32'h0000_0100, 3'b001, 1'b1, 5'd16, 32'h0000_0200},
        {32'h0000_0100, 3'b101, 1'b1, 5'd16, 32'h0000_0300},
        {32'h0000_0100, 3'b011, 1'b0, 5'd0,  32'h0000_0000},
        {32'h0000_0100, 3'b000, 1'b0, 5'd0,  32'h0000_0000},
        {32'h0000_0124, 3'b010, 1'b1, 5'd7,  32'h0000_0400},
        {32'h0000_0124, 3'b110, 1'b1, 5'd7,  32'h0000_0400},
        {32'h0000_0124, 3'b011, 1'b0, 5'd0,  32'h0000_0000},
        {32'h0000_0048, 3'b000, 1'b1, 5'd3,  32'h0000_0600},
        {32'h0000_0048, 3'b001, 1'b1, 5'd3,  32'h0000_0700},
        {32'h0000_0048, 3'b110, 1'b1, 5'd3,  32'h0000_0600},
        {32'h0000_00C0, 3'b111, 1'b1, 5'd5,  32'h0000_0800},
        {32'h0000_0200, 3'b001, 1'b0, 5'd0,  32'h0000_0000},
        {32'h0000_0010, 3'b000, 1'b0, 5'd0,  32'h0000_0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0] req_pred = '0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_start_addr = '0;
    logic [LW-1:0] wr_insns = '0;
    logic [4:0] wr_count = '0;
    logic [1:0] wr_br_count = '0;
    logic wr_ends_br = 1'b0;
    logic [2:0] wr_dir_flags = '0;
    logic [AW-1:0] wr_fall_addr = '0;
    logic [AW-1:0] wr_target_addr = '0;
    logic hit;
    logic [LW-1:0] insns;
    logic [4:0] insn_count;
    logic [AW-1:0] next_addr;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    trace_lookup_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_pred(req_pred), .wr_en(wr_en), .wr_start_addr(wr_start_addr),
        .wr_insns(wr_insns), .wr_count(wr_count), .wr_br_count(wr_br_count),
        .wr_ends_br(wr_ends_br), .wr_dir_flags(wr_dir_flags),
        .wr_fall_addr(wr_fall_addr), .wr_target_addr(wr_target_addr),
        .hit(hit), .insns(insns), .insn_count(insn_count), .next_addr(next_addr)
    );

    function automatic logic [LW-1:0] words_for(input logic [AW-1:0] a);
        logic [LW-1:0] w;
        for (int i = 0; i < NI; i++) w[i*IW +: IW] = {a[15:0], 16'(i)};
        return w;
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_write(input logic [AW-1:0] a, input logic [4:0] cnt, input logic [1:0] brc,
                             input logic ends, input logic [2:0] fl,
                             input logic [AW-1:0] ft, input logic [AW-1:0] tg);
        wr_en = 1'b1; wr_start_addr = a; wr_insns = words_for(a); wr_count = cnt;
        wr_br_count = brc; wr_ends_br = ends; wr_dir_flags = fl;
        wr_fall_addr = ft; wr_target_addr = tg;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [4:0] cnt, input logic [1:0] brc,
                            input logic ends, input logic [2:0] fl,
                            input logic [AW-1:0] ft, input logic [AW-1:0] tg);
        @(negedge clk);
        put_write(a, cnt, brc, ends, fl, ft, tg);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic [2:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_pred = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs clear and an unwritten line misses
        check("R1 reset hit", AW'(hit), 0);
        lookup(32'h0000_0100, 3'b001);
        check("R1 empty store lookup", AW'(hit), 0);

        do_write(32'h0000_0100, 5'd16, 2'd3, 1'b1, 3'b001, 32'h200, 32'h300);
        do_write(32'h0000_0124, 5'd7,  2'd2, 1'b0, 3'b010, 32'h400, 32'h500);
        do_write(32'h0000_0048, 5'd3,  2'd1, 1'b1, 3'b000, 32'h600, 32'h700);
        do_write(32'h0000_00C0, 5'd5,  2'd0, 1'b0, 3'b000, 32'h800, 32'h880);

        // R3 R4 R5 R6 R7 R8: table walk
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            logic [2:0] p;
            logic eh;
            logic [4:0] ec;
            logic [AW-1:0] en;
            {a, p, eh, ec, en} = VEC[v];
            lookup(a, p);
            check($sformatf("R4/R5 hit vec %0d", v), AW'(hit), AW'(eh));
            check($sformatf("R8 count vec %0d", v), AW'(insn_count), AW'(ec));
            check($sformatf("R6/R7 next vec %0d", v), next_addr, en);
            checks++;
            if (insns !== (eh ? words_for(a) : '0)) begin
                errors++;
                $display("FAIL R8 insns vec %0d actual %h expected %h", v, insns[31:0],
                         eh ? words_for(a) : '0);
            end
        end

        // R2: result holds one cycle then clears with no new request
        lookup(32'h0000_0124, 3'b010);
        check("R2 answered next edge", AW'(hit), 1);
        @(negedge clk);
        check("R10 idle cycle no hit", AW'(hit), 0);

        // R10: req_valid low on a hitting address
        @(negedge clk);
        req_valid = 1'b0; req_addr = 32'h0000_0124; req_pred = 3'b010;
        @(negedge clk);
        check("R10 no request", AW'(hit), 0);

        // R9: same-cycle write and lookup on line 0
        @(negedge clk);
        put_write(32'h0000_0100, 5'd9, 2'd3, 1'b1, 3'b001, 32'h900, 32'h300);
        req_valid = 1'b1; req_addr = 32'h0000_0100; req_pred = 3'b001;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R9 old contents", next_addr, 32'h200);
        check("R9 old count", AW'(insn_count), 16);
        lookup(32'h0000_0100, 3'b001);
        check("R9 new contents", next_addr, 32'h900);
        check("R9 new count", AW'(insn_count), 9);

        // R3: overwrite index 0 with another tag
        do_write(32'h0000_0200, 5'd4, 2'd0, 1'b0, 3'b000, 32'hA00, 32'hB00);
        lookup(32'h0000_0100, 3'b001);
        check("R3 replaced tag misses", AW'(hit), 0);
        lookup(32'h0000_0200, 3'b111);
        check("R3 new tag hits", next_addr, 32'hA00);
        lookup(32'h0000_0201, 3'b000);
        check("R3 offset bits in tag", AW'(hit), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule